// File: doc/BRIEF.md
# Context-Tagged Second-Stage Translation Cache

This block is a small fully associative cache of second-stage address translations. Each entry maps a guest-physical frame to a host-physical frame. It also keeps read, write and execute permission bits. Every entry is tagged with a virtual processor identifier and a translation context identifier. A lookup presents a guest-physical address. One cycle later the block returns a hit flag, the host-physical address and the cached permissions. The two tags of the matching entry must equal the current identifiers driven on `cur_vpid` and `cur_ctx`.

A table walker, which lies outside this block, fills entries through a fill port. An entry can cover a 4 KB, 2 MB or 1 GB region, and entries of all three sizes can sit in the table together. When software changes a mapping, it issues an invalidate command. The command removes either the entries of one (processor, context) pair or every entry. Guests can therefore be switched without flushing the translations of other guests.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup hits only on a valid entry whose processor tag equals `cur_vpid`, whose context tag equals `cur_ctx`, and whose region contains the requested address. Changing `cur_vpid` or `cur_ctx` removes no entry.
- R2: The lookup result is registered. `lk_hit`, `lk_hpa` and `lk_perm` reflect the request of the previous cycle. On a miss, or with no request, all three are zero. The permission encoding is bit 0 read, bit 1 write, bit 2 execute.
- R3: For a 4 KB entry, the host address is the cached host frame followed by request bits [11:0].
- R4: The size code is 0 for 4 KB, 1 for 2 MB and 2 for 1 GB, and code 3 is treated as 4 KB. A 2 MB entry matches any address in its region and takes the low 21 bits of the host address from the request. A 1 GB entry does the same with the low 30 bits.
- R5: A context invalidate (`inv_all`=0) removes exactly the entries whose tags equal `inv_vpid` and `inv_ctx`. All other entries keep hitting.
- R6: A global invalidate (`inv_all`=1) removes every entry.
- R7: An invalidate takes effect in one cycle. A lookup in the same cycle is answered from the table after the invalidation. A fill in the same cycle is written after the invalidation and survives it.
- R8: A fill whose processor tag, context tag, size and region equal those of a valid entry overwrites that entry and allocates no second one.
- R9: A new fill takes the lowest-numbered free entry. When all 16 entries are valid, the fill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, with wrap-around, on each replacement.
- R10: After reset no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_vpid | input | 8 | Current virtual processor identifier |
| cur_ctx | input | 8 | Current translation context identifier |
| lk_valid | input | 1 | Lookup request |
| lk_gpa | input | 48 | Guest-physical address to translate |
| lk_hit | output | 1 | Lookup hit (one cycle after request) |
| lk_hpa | output | 48 | Host-physical address |
| lk_perm | output | 3 | Cached permissions {x,w,r} |
| fill_valid | input | 1 | Fill request |
| fill_vpid | input | 8 | Processor tag of the fill |
| fill_ctx | input | 8 | Context tag of the fill |
| fill_gpa | input | 48 | Guest-physical base of the fill |
| fill_hpa | input | 48 | Host-physical base of the fill |
| fill_size | input | 2 | Region size code |
| fill_perm | input | 3 | Permissions of the fill |
| inv_valid | input | 1 | Invalidate command |
| inv_all | input | 1 | 1: global, 0: one context |
| inv_vpid | input | 8 | Processor tag to invalidate |
| inv_ctx | input | 8 | Context tag to invalidate |

## Verification
A stale valid bit or a corrupted tag shows up on the next lookup as a wrong hit or a wrong miss, one cycle after the request. A wrong size field or a wrong frame shows up in the same cycle as a wrong `lk_hpa`, usually in the bits above the request offset. A replacement pointer that drifts stays hidden until the table is full. The next fill then evicts the wrong entry, and the fault appears only when the evicted and surviving translations are looked up again. The scenarios therefore fill the table completely and probe neighbours of each victim.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    localparam int GPA_W  = 48;
    localparam int HPA_W  = 48;
    localparam int VPID_W = 8;
    localparam int CTX_W  = 8;
    localparam int OFF_W  = 12;
    localparam int GFN_W  = GPA_W - OFF_W;
    localparam int HFN_W  = HPA_W - OFF_W;
    localparam int LARGE_W = 18;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic              vld;
        logic [VPID_W-1:0] vpid;
        logic [CTX_W-1:0]  ctx;
        pg_size_e          size;
        logic [GFN_W-1:0]  gfn;
        logic [HFN_W-1:0]  hfn;
        logic [2:0]        perm;
    } ent_t;

    // Low frame bits that come from the request for a given size.
    function automatic logic [LARGE_W-1:0] low_mask(pg_size_e s);
        case (s)
            PG_2M:   return LARGE_W'(18'h001FF);
            PG_1G:   return LARGE_W'(18'h3FFFF);
            default: return '0;
        endcase
    endfunction

    function automatic pg_size_e norm_size(logic [1:0] code);
        return (code == 2'd3) ? PG_4K : pg_size_e'(code);
    endfunction
endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
    import ctx_tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  ent_t [N-1:0]      tbl,
    input  logic [N-1:0]      vld,
    input  logic [VPID_W-1:0] vpid,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [GFN_W-1:0]  gfn,
    input  logic              exact,
    input  pg_size_e          size,
    output logic [N-1:0]      hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [LARGE_W-1:0] m;
        logic               frame_eq;
        logic               tag_eq;
        always_comb begin
            m        = low_mask(tbl[i].size);
            frame_eq = (gfn[GFN_W-1:LARGE_W] == tbl[i].gfn[GFN_W-1:LARGE_W]) &&
                       ((gfn[LARGE_W-1:0] & ~m) == tbl[i].gfn[LARGE_W-1:0]);
            tag_eq   = (tbl[i].vpid == vpid) && (tbl[i].ctx == ctx);
            hit[i]   = vld[i] && tag_eq && frame_eq && (!exact || tbl[i].size == size);
        end
    end
endmodule

// File: rtl/ctx_tlb_pick.sv
module ctx_tlb_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     dup,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] idx,
    output logic             evict
);
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup[i])  dup_idx  = IDX_W'(i);
            if (!vld[i]) free_idx = IDX_W'(i);
        end
        evict = 1'b0;
        if (|dup) begin
            idx = dup_idx;
        end else if (!(&vld)) begin
            idx = free_idx;
        end else begin
            idx   = rr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPID_W-1:0] cur_vpid,
    input  logic [CTX_W-1:0]  cur_ctx,
    input  logic              lk_valid,
    input  logic [GPA_W-1:0]  lk_gpa,
    output logic              lk_hit,
    output logic [HPA_W-1:0]  lk_hpa,
    output logic [2:0]        lk_perm,
    input  logic              fill_valid,
    input  logic [VPID_W-1:0] fill_vpid,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [GPA_W-1:0]  fill_gpa,
    input  logic [HPA_W-1:0]  fill_hpa,
    input  logic [1:0]        fill_size,
    input  logic [2:0]        fill_perm,
    input  logic              inv_valid,
    input  logic              inv_all,
    input  logic [VPID_W-1:0] inv_vpid,
    input  logic [CTX_W-1:0]  inv_ctx
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        ent_t [ENTRIES-1:0] tbl;
        logic [IDX_W-1:0]   rr;
        logic               hit;
        logic [HPA_W-1:0]   hpa;
        logic [2:0]         perm;
    } st_t;

    st_t st_d, st_q;

    logic [ENTRIES-1:0] vld_now;
    logic [ENTRIES-1:0] vld_post;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fill_vec;
    logic               fill_dup;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_evict;
    pg_size_e           f_size;
    logic [GFN_W-1:0]   f_gfn;
    logic [HFN_W-1:0]   f_hfn;

    // Valid mask after any invalidate of this cycle.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_now[i]  = st_q.tbl[i].vld;
            vld_post[i] = st_q.tbl[i].vld &&
                          !(inv_valid && (inv_all ||
                            (st_q.tbl[i].vpid == inv_vpid && st_q.tbl[i].ctx == inv_ctx)));
        end
        f_size = norm_size(fill_size);
        f_gfn  = {fill_gpa[GPA_W-1:OFF_W+LARGE_W],
                  fill_gpa[OFF_W+LARGE_W-1:OFF_W] & ~low_mask(f_size)};
        f_hfn  = {fill_hpa[HPA_W-1:OFF_W+LARGE_W],
                  fill_hpa[OFF_W+LARGE_W-1:OFF_W] & ~low_mask(f_size)};
    end

    ctx_tlb_match #(.N(ENTRIES)) u_lk_match (
        .tbl   (st_q.tbl),
        .vld   (vld_post),
        .vpid  (cur_vpid),
        .ctx   (cur_ctx),
        .gfn   (lk_gpa[GPA_W-1:OFF_W]),
        .exact (1'b0),
        .size  (PG_4K),
        .hit   (lk_vec)
    );

    ctx_tlb_match #(.N(ENTRIES)) u_fill_match (
        .tbl   (st_q.tbl),
        .vld   (vld_post),
        .vpid  (fill_vpid),
        .ctx   (fill_ctx),
        .gfn   (f_gfn),
        .exact (1'b1),
        .size  (f_size),
        .hit   (fill_vec)
    );

    assign fill_dup = |fill_vec;

    ctx_tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .vld   (vld_post),
        .dup   (fill_vec),
        .rr    (st_q.rr),
        .idx   (fill_idx),
        .evict (fill_evict)
    );

    always_comb begin
        ent_t               sel;
        logic               found;
        logic [LARGE_W-1:0] m;
        st_d  = st_q;
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.tbl[i].vld = vld_post[i];
            if (lk_vec[i] && !found) begin
                sel   = st_q.tbl[i];
                found = 1'b1;
            end
        end
        m         = low_mask(sel.size);
        st_d.hit  = lk_valid && found;
        st_d.hpa  = '0;
        st_d.perm = '0;
        if (lk_valid && found) begin
            st_d.hpa  = {sel.hfn[HFN_W-1:LARGE_W],
                         (sel.hfn[LARGE_W-1:0] & ~m) | (lk_gpa[OFF_W+LARGE_W-1:OFF_W] & m),
                         lk_gpa[OFF_W-1:0]};
            st_d.perm = sel.perm;
        end
        if (fill_valid) begin
            st_d.tbl[fill_idx] = '{vld: 1'b1, vpid: fill_vpid, ctx: fill_ctx, size: f_size,
                                   gfn: f_gfn, hfn: f_hfn, perm: fill_perm};
            if (fill_evict) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit  = st_q.hit;
    assign lk_hpa  = st_q.hpa;
    assign lk_perm = st_q.perm;
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
    parameter int N     = 16,
    parameter int GPA_W = 48,
    parameter int HPA_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [GPA_W-1:0] lk_gpa,
    input logic             lk_hit,
    input logic [HPA_W-1:0] lk_hpa,
    input logic [2:0]       lk_perm,
    input logic             fill_valid,
    input logic             inv_valid,
    input logic             inv_all,
    input logic [N-1:0]     vld_vec,
    input logic             fill_dup
);
    a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid));

    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_hpa == '0 && lk_perm == 3'b000));

    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_hpa[11:0] == $past(lk_gpa[11:0]));

    a_r6_global_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_all && !fill_valid) |=> vld_vec == '0);

    a_r7_inv_before_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_all && lk_valid) |=> !lk_hit);

    a_r8_dup_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_dup && !inv_valid) |=>
            $countones(vld_vec) == $past($countones(vld_vec)));

    a_r9_free_slot_used: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_dup && !inv_valid && !(&vld_vec)) |=>
            $countones(vld_vec) == $past($countones(vld_vec)) + 1);
endmodule

bind ctx_tlb ctx_tlb_chk #(.N(ENTRIES), .GPA_W(ctx_tlb_pkg::GPA_W), .HPA_W(ctx_tlb_pkg::HPA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_gpa     (lk_gpa),
    .lk_hit     (lk_hit),
    .lk_hpa     (lk_hpa),
    .lk_perm    (lk_perm),
    .fill_valid (fill_valid),
    .inv_valid  (inv_valid),
    .inv_all    (inv_all),
    .vld_vec    (vld_now),
    .fill_dup   (fill_dup)
);

// File: tb/ctx_tlb_bench.sv
`timescale 1ns/1ps
module ctx_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_vpid = 8'h11, cur_ctx = 8'h22;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_gpa = '0;
    logic        lk_hit;
    logic [47:0] lk_hpa;
    logic [2:0]  lk_perm;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_vpid = '0, fill_ctx = '0;
    logic [47:0] fill_gpa = '0, fill_hpa = '0;
    logic [1:0]  fill_size = '0;
    logic [2:0]  fill_perm = '0;
    logic        inv_valid = 1'b0, inv_all = 1'b0;
    logic [7:0]  inv_vpid = '0, inv_ctx = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ctx_tlb u_ctx_tlb (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic fill(logic [7:0] v, logic [7:0] c, logic [47:0] g, logic [47:0] h,
                        logic [1:0] s, logic [2:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpid = v; fill_ctx = c;
        fill_gpa = g; fill_hpa = h; fill_size = s; fill_perm = p;
        @(negedge clk); fill_valid = 1'b0;
    endtask

    task automatic inv(logic all, logic [7:0] v, logic [7:0] c);
        @(negedge clk);
        inv_valid = 1'b1; inv_all = all; inv_vpid = v; inv_ctx = c;
        @(negedge clk); inv_valid = 1'b0;
    endtask

    task automatic look(logic [47:0] g);
        @(negedge clk); lk_valid = 1'b1; lk_gpa = g;
        @(negedge clk); lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look(48'h0000_1234_5ABC);
        chk("R10 miss after reset", {63'd0, lk_hit}, 64'd0);
        chk("R2 zero hpa on miss", {16'd0, lk_hpa}, 64'd0);
    endtask

    task automatic t_basic();
        fill(8'h11, 8'h22, 48'h0000_1234_5000, 48'h0000_ABCD_E000, 2'd0, 3'b101);
        look(48'h0000_1234_5ABC);
        chk("R1 hit", {63'd0, lk_hit}, 64'd1);
        chk("R3 4K hpa", {16'd0, lk_hpa}, {16'd0, 48'h0000_ABCD_EABC});
        chk("R2 perm", {61'd0, lk_perm}, 64'd5);
        look(48'h0000_1234_6ABC);
        chk("R1 next page misses", {63'd0, lk_hit}, 64'd0);
        cur_vpid = 8'h12;
        look(48'h0000_1234_5ABC);
        chk("R1 vpid mismatch misses", {63'd0, lk_hit}, 64'd0);
        cur_vpid = 8'h11; cur_ctx = 8'h23;
        look(48'h0000_1234_5ABC);
        chk("R1 ctx mismatch misses", {63'd0, lk_hit}, 64'd0);
        cur_ctx = 8'h22;
        look(48'h0000_1234_5ABC);
        chk("R1 entry kept across switch", {63'd0, lk_hit}, 64'd1);
    endtask

    task automatic t_large();
        fill(8'h11, 8'h22, 48'h0000_4020_0000, 48'h0000_8060_0000, 2'd1, 3'b011);
        look(48'h0000_4031_2345);
        chk("R4 2M hit", {63'd0, lk_hit}, 64'd1);
        chk("R4 2M hpa", {16'd0, lk_hpa}, {16'd0, 48'h0000_8071_2345});
        fill(8'h11, 8'h22, 48'h00C0_0000_0000, 48'h0100_4000_0000, 2'd2, 3'b100);
        look(48'h00C0_1234_5678);
        chk("R4 1G hpa", {16'd0, lk_hpa}, {16'd0, 48'h0100_5234_5678});
        chk("R4 1G perm", {61'd0, lk_perm}, 64'd4);
        look(48'h00C0_4000_0000);
        chk("R4 1G region end misses", {63'd0, lk_hit}, 64'd0);
    endtask

    task automatic t_inv();
        fill(8'h11, 8'h33, 48'h0000_7000_0000, 48'h0000_9000_0000, 2'd0, 3'b001);
        inv(1'b0, 8'h11, 8'h22);
        look(48'h0000_1234_5ABC);
        chk("R5 target ctx removed", {63'd0, lk_hit}, 64'd0);
        cur_ctx = 8'h33;
        look(48'h0000_7000_0010);
        chk("R5 other ctx kept", {16'd0, lk_hpa}, {16'd0, 48'h0000_9000_0010});
        inv(1'b1, 8'h00, 8'h00);
        look(48'h0000_7000_0010);
        chk("R6 global removes all", {63'd0, lk_hit}, 64'd0);
        cur_ctx = 8'h22;
    endtask

    task automatic t_same_cycle();
        fill(8'h11, 8'h22, 48'h0000_1234_5000, 48'h0000_ABCD_E000, 2'd0, 3'b111);
        @(negedge clk);
        inv_valid = 1'b1; inv_all = 1'b0; inv_vpid = 8'h11; inv_ctx = 8'h22;
        lk_valid = 1'b1; lk_gpa = 48'h0000_1234_5000;
        @(negedge clk);
        inv_valid = 1'b0; lk_valid = 1'b0;
        chk("R7 lookup sees invalidate", {63'd0, lk_hit}, 64'd0);
        @(negedge clk);
        inv_valid = 1'b1; inv_all = 1'b1;
        fill_valid = 1'b1; fill_vpid = 8'h11; fill_ctx = 8'h22;
        fill_gpa = 48'h0000_5555_5000; fill_hpa = 48'h0000_6666_6000;
        fill_size = 2'd0; fill_perm = 3'b010;
        @(negedge clk);
        inv_valid = 1'b0; fill_valid = 1'b0;
        look(48'h0000_5555_5004);
        chk("R7 fill survives invalidate", {16'd0, lk_hpa}, {16'd0, 48'h0000_6666_6004});
    endtask

    task automatic t_replace();
        logic [47:0] ga, ha;
        int ok;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            ga = 48'h0000_0010_0000 + (48'(i) << 12);
            ha = 48'h0000_2000_0000 + (48'(i) << 12);
            fill(8'h11, 8'h22, ga, ha, 2'd0, 3'b001);
        end
        fill(8'h11, 8'h22, 48'h0000_0010_3000, 48'h0000_3000_0000, 2'd0, 3'b011);
        ok = 0;
        for (int i = 0; i < 16; i++) begin
            look(48'h0000_0010_0000 + (48'(i) << 12));
            if (lk_hit) ok++;
        end
        chk("R8 duplicate fill keeps all 16", 64'(ok), 64'd16);
        look(48'h0000_0010_3008);
        chk("R8 duplicate overwrote hpa", {16'd0, lk_hpa}, {16'd0, 48'h0000_3000_0008});
        fill(8'h11, 8'h22, 48'h0000_0050_0000, 48'h0000_4000_0000, 2'd0, 3'b001);
        look(48'h0000_0010_0000);
        chk("R9 first victim is slot 0", {63'd0, lk_hit}, 64'd0);
        look(48'h0000_0010_1000);
        chk("R9 slot 1 kept", {63'd0, lk_hit}, 64'd1);
        look(48'h0000_0050_0000);
        chk("R9 new entry hits", {63'd0, lk_hit}, 64'd1);
        fill(8'h11, 8'h22, 48'h0000_0051_0000, 48'h0000_4100_0000, 2'd0, 3'b001);
        look(48'h0000_0010_1000);
        chk("R9 pointer advanced to slot 1", {63'd0, lk_hit}, 64'd0);
        look(48'h0000_0010_2000);
        chk("R9 slot 2 kept", {63'd0, lk_hit}, 64'd1);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_large();
        t_inv();
        t_same_cycle();
        t_replace();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule